// File: doc/BRIEF.md
# Byte-Lane Pseudo-Static RAM Access Controller

This block connects a simple on-chip request port to an external asynchronous pseudo-static RAM. The RAM holds 16-bit words and has a separate active-low enable for each byte lane. A requester offers a read or a write with an 18-bit word address, write data and a two-bit lane mask, using a valid/ready handshake. The controller then runs the memory strobes: chip enable, write enable, output enable and the two lane enables. It also tells the pad logic when the controller may drive the shared data bus. When an access ends, it raises a one-cycle done pulse, and a read returns its data at that same time.

All access timing is counted in clock cycles. By default the strobe widths are the memory speed grade (55, 60 or 70 ns) divided by the clock period and rounded up. The address-setup, turnaround and deselect-gap lengths are parameters as well. A request that arrives in the cycle after the previous access completes keeps chip enable low, which saves the deselect and reselect. The memory hides its own refresh behind the time chip enable is high, so a selection counter limits how long chip enable may stay low. Before that limit would be passed, the controller inserts a deselect gap.

Top module: `psram_lane_ctrl`

## Requirements
- R1: After reset, and while reset is held, mem_ce_n, mem_we_n, mem_oe_n and both bits of mem_be_n are 1, mem_dq_oe and done are 0, and req_ready is 1.
- R2: A write with a nonzero mask drives mem_we_n low while mem_ce_n is low. mem_be_n is the inverse of the mask. Mask bit 0 selects data bits 7:0 and mem_be_n[0]; mask bit 1 selects data bits 15:8 and mem_be_n[1]. Only the selected lanes of the addressed word change.
- R3: A read with a nonzero mask drives mem_oe_n low while mem_we_n stays high. done then pulses with rdata holding the selected lanes of the word, and an unselected lane reads as 0.
- R4: mem_dq_oe is 1 only while mem_ce_n and mem_we_n are both low, and never while mem_oe_n is low.
- R5: In the cycle after any cycle with mem_oe_n low, mem_dq_oe is 0.
- R6: Each write keeps mem_we_n low for exactly WR_PULSE_CYC cycles, and each read keeps mem_oe_n low for exactly RD_WAIT_CYC cycles. Both default to ceil(SPEED_NS / CLK_NS), which is 9 cycles at 70 ns and 8 ns.
- R7: A request with mask 2'b00 gives done in the next cycle and rdata equal to 0. It leaves mem_ce_n high and the memory contents unchanged.
- R8: A request accepted in the cycle after the previous access completes keeps mem_ce_n low across both accesses, unless R9 forces a gap.
- R9: mem_ce_n is never low for more than SEL_LIMIT_CYC consecutive cycles. A long chain of accesses is broken by a deselect gap of at least one cycle, and the chain then continues.
- R10: req_ready is 1 only while the controller is idle. Every accepted request produces exactly one done pulse.
- R11: mem_addr carries the full 18-bit request address during the access, so word 0x3FFFF and word 0x00010 are distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 1 high byte |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory pads |

## Verification
The checker assumes that reset is high from time zero until the first clock edges. It also assumes that req_valid and the request fields stay stable from the time they are raised until the handshake. The bench drives these inputs only at falling edges and holds them until it sees req_ready, so it stays within both assumptions. The memory model returns a poison pattern on unselected lanes and when output enable is off, so any lane masking the controller leaves out shows up in rdata. Chaining and the selection limit are tested with the limit lowered so that a stream of twenty reads has to cross it.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_WRITE,
    ST_READ,
    ST_TURN
  } ctrl_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_phase_timer.sv
// Down-counter for one strobe phase: a load of N-1 gives a phase of N cycles.
module psram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/psram_sel_guard.sv
// Counts consecutive cycles with chip enable low; allows chaining only below a margin.
module psram_sel_guard #(
  parameter int SEL_LIMIT_CYC = 1750,
  parameter int CHAIN_MAX     = 1700
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  output logic chain_ok
);
  localparam int CW = $clog2(SEL_LIMIT_CYC + 2);
  localparam logic [CW-1:0] TOP  = CW'(SEL_LIMIT_CYC);
  localparam logic [CW-1:0] EDGE = CW'(CHAIN_MAX);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || ce_n)    run <= '0;
    else if (run != TOP) run <= run + 1'b1;
  end

  assign chain_ok = (run <= EDGE);
endmodule

// File: rtl/psram_lane_map.sv
// Lane enables from a mask, and per-lane masking of returned read data.
module psram_lane_map #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*8-1:0] raw,
  output logic [LANES-1:0]   be_n,
  output logic [LANES*8-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n[g]          = ~mask[g];
    assign merged[g*8 +: 8] = mask[g] ? raw[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_lane_ctrl.sv
module psram_lane_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_NS        = 8,
  parameter int SPEED_NS      = 70,
  parameter int SETUP_CYC     = 1,
  parameter int WR_PULSE_CYC  = ceil_div(SPEED_NS, CLK_NS),
  parameter int RD_WAIT_CYC   = ceil_div(SPEED_NS, CLK_NS),
  parameter int TURN_CYC      = 1,
  parameter int GAP_CYC       = 1,
  parameter int SEL_LIMIT_CYC = 14000 / CLK_NS,
  localparam int LANES        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // Longest chip-enable-low stretch of one access, and the chaining margin.
  localparam int ACC_MAX   = SETUP_CYC + max2(RD_WAIT_CYC + TURN_CYC, WR_PULSE_CYC);
  localparam int CHAIN_MAX = SEL_LIMIT_CYC - ACC_MAX - 4;
  localparam int TMAX      = max2(max2(SETUP_CYC, GAP_CYC),
                                  max2(max2(WR_PULSE_CYC, RD_WAIT_CYC), TURN_CYC));
  localparam int TW        = $clog2(TMAX + 1);

  ctrl_state_t      state;
  logic             op_write;
  logic [LANES-1:0] op_mask;
  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] lane_be_n;
  logic [DATA_W-1:0] rd_merged;
  logic             chain_ok;
  logic             tmr_load;
  logic [TW-1:0]    tmr_val;
  logic             tmr_exp;
  logic             take_req;
  logic             need_gap;

  assign req_ready = (state == ST_IDLE);
  assign take_req  = req_ready && req_valid && (req_mask != '0);
  assign need_gap  = !mem_ce_n && !chain_ok;
  assign lane_sel  = (state == ST_IDLE) ? req_mask : op_mask;

  psram_lane_map #(.LANES(LANES)) u_lanes (
    .mask   (lane_sel),
    .raw    (mem_dq_i),
    .be_n   (lane_be_n),
    .merged (rd_merged)
  );

  psram_sel_guard #(.SEL_LIMIT_CYC(SEL_LIMIT_CYC), .CHAIN_MAX(CHAIN_MAX)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (mem_ce_n),
    .chain_ok (chain_ok)
  );

  psram_phase_timer #(.CW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  // Timer reloads on every phase entry.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (take_req) begin
        tmr_load = 1'b1;
        tmr_val  = need_gap ? TW'(GAP_CYC - 1) : TW'(SETUP_CYC - 1);
      end
      ST_GAP: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = op_write ? TW'(WR_PULSE_CYC - 1) : TW'(RD_WAIT_CYC - 1);
      end
      ST_READ: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(TURN_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_write  <= 1'b0;
      op_mask   <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_mask == '0) begin
            done     <= 1'b1;
            rdata    <= '0;
            mem_ce_n <= 1'b1;
          end else if (take_req) begin
            op_write <= req_write;
            op_mask  <= req_mask;
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
            if (need_gap) begin
              state    <= ST_GAP;
              mem_ce_n <= 1'b1;
            end else begin
              state    <= ST_SETUP;
              mem_ce_n <= 1'b0;
              mem_be_n <= lane_be_n;
            end
          end else begin
            mem_ce_n <= 1'b1;
          end
        end
        ST_GAP: if (tmr_exp) begin
          state    <= ST_SETUP;
          mem_ce_n <= 1'b0;
          mem_be_n <= lane_be_n;
        end
        ST_SETUP: if (tmr_exp) begin
          if (op_write) begin
            state     <= ST_WRITE;
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
          end else begin
            state    <= ST_READ;
            mem_oe_n <= 1'b0;
          end
        end
        ST_WRITE: if (tmr_exp) begin
          state     <= ST_IDLE;
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          mem_be_n  <= '1;
          done      <= 1'b1;
        end
        ST_READ: if (tmr_exp) begin
          state    <= ST_TURN;
          mem_oe_n <= 1'b1;
          mem_be_n <= '1;
          rdata    <= rd_merged;
          done     <= 1'b1;
        end
        ST_TURN: if (tmr_exp) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psram_lane_ctrl_chk.sv
module psram_lane_ctrl_chk #(
  parameter int WR_PULSE_CYC  = 9,
  parameter int RD_WAIT_CYC   = 9,
  parameter int SEL_LIMIT_CYC = 1750
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_mask,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       mem_oe_n,
  input logic       mem_dq_oe
);
  int ce_run;
  int we_len;
  int oe_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_run <= 0;
      we_len <= 0;
      oe_len <= 0;
    end else begin
      ce_run <= mem_ce_n ? 0 : ce_run + 1;
      we_len <= mem_we_n ? 0 : we_len + 1;
      oe_len <= mem_oe_n ? 0 : oe_len + 1;
    end
  end

  // R4: drive only inside a write strobe
  a_r4_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n));
  // R4: never drive against the memory outputs
  a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  // R5: turnaround after output enable
  a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |=> !mem_dq_oe);
  // R3: read and write strobes exclusive
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));
  // R6: strobe widths
  a_r6_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_len == WR_PULSE_CYC));
  a_r6_oe_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_len == RD_WAIT_CYC));
  // R9: continuous-select limit
  a_r9_sel_limit: assert property (@(posedge clk) disable iff (rst)
    ce_run <= SEL_LIMIT_CYC);
  // R7: empty mask never selects the chip
  a_r7_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mask == 2'b00) |=> mem_ce_n);
endmodule

bind psram_lane_ctrl psram_lane_ctrl_chk #(
  .WR_PULSE_CYC  (WR_PULSE_CYC),
  .RD_WAIT_CYC   (RD_WAIT_CYC),
  .SEL_LIMIT_CYC (SEL_LIMIT_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mask  (req_mask),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_psram_lane_ctrl.sv
`timescale 1ns/1ps
module test_psram_lane_ctrl;
  localparam int LIMIT   = 80;
  localparam int EXP_ACC = (70 + 8 - 1) / 8;  // 9 cycles

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        done;
  logic [15:0] rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hA5A5;

  int checks = 0;
  int errors = 0;
  int accepts = 0;
  int dones = 0;
  int ce_run = 0, max_run = 0, gaps = 0;
  int we_run = 0, oe_run = 0;
  bit prev_oe_low = 0;
  bit ce_seen = 0;

  always #4 clk = ~clk;

  psram_lane_ctrl #(.CLK_NS(8), .SPEED_NS(70), .SEL_LIMIT_CYC(LIMIT)) i_psram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .done(done), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Sparse behavioural memory.
  logic [15:0] store [int];

  function automatic logic [15:0] peek(input logic [17:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : 16'h0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Memory model and protocol monitor, on falling edges.
  always @(negedge clk) begin
    logic [15:0] w;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      w = peek(mem_addr);
      if (!mem_be_n[0]) w[7:0]  = mem_dq_o[7:0];
      if (!mem_be_n[1]) w[15:8] = mem_dq_o[15:8];
      store[int'(mem_addr)] = w;
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      w = peek(mem_addr);
      mem_dq_i <= {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'hA5 : w[7:0]};
    end else begin
      mem_dq_i <= 16'hA5A5;
    end
    if (rst) begin
      ce_run = 0; we_run = 0; oe_run = 0; prev_oe_low = 0;
    end else begin
      if (mem_dq_oe && (mem_ce_n || mem_we_n || !mem_oe_n))
        check("R4 drive outside write window", 1, 0);
      if (prev_oe_low && mem_dq_oe) check("R5 drive right after read", 1, 0);
      prev_oe_low = !mem_oe_n;
      if (!mem_ce_n) begin ce_run++; ce_seen = 1; end
      else begin
        if (ce_run > 0) gaps++;
        if (ce_run > max_run) max_run = ce_run;
        ce_run = 0;
      end
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin check("R6 write strobe width", we_run, EXP_ACC); we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin check("R6 read strobe width", oe_run, EXP_ACC); oe_run = 0; end
      if (done) dones++;
    end
  end

  // Called at a falling edge; returns at the falling edge where done is seen.
  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    accepts++;
    #1 req_valid = 1'b0;
    @(negedge clk);
    if (m != 2'b00) check("R10 ready low while busy", req_ready, 0);
    while (!done) @(negedge clk);
  endtask

  // {write, addr, wdata, mask, expected rdata}
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 18'h00010, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 18'h00010, 16'hABCD, 2'b01, 16'h0000},
    {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h12CD},
    {1'b1, 18'h00010, 16'h9900, 2'b10, 16'h0000},
    {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h99CD},
    {1'b0, 18'h00010, 16'h0000, 2'b01, 16'h00CD},
    {1'b0, 18'h00010, 16'h0000, 2'b10, 16'h9900},
    {1'b1, 18'h3FFFF, 16'h5A5A, 2'b11, 16'h0000},
    {1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'h5A5A},
    {1'b1, 18'h3FFFF, 16'hFFFF, 2'b00, 16'h0000},
    {1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'h5A5A},
    {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h99CD}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ce_n", mem_ce_n, 1);   check("R1 we_n", mem_we_n, 1);
    check("R1 oe_n", mem_oe_n, 1);   check("R1 be_n", mem_be_n, 2'b11);
    check("R1 dq_oe", mem_dq_oe, 0); check("R1 done", done, 0);
    check("R1 ready", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R7 R11: table walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][52], VEC[i][51:34], VEC[i][33:18], VEC[i][17:16]);
      if (!VEC[i][52]) check($sformatf("R3 R11 read data vector %0d", i), rdata, VEC[i][15:0]);
      else             check($sformatf("R2 write done vector %0d", i), done, 1);
      repeat (2) @(negedge clk);
    end
    check("R11 top word distinct", peek(18'h3FFFF), 16'h5A5A);

    // R7: empty mask keeps chip deselected and answers next cycle
    repeat (3) @(negedge clk);
    ce_seen = 0;
    req_valid = 1'b1; req_write = 1'b0; req_mask = 2'b00; req_addr = 18'h00010;
    @(posedge clk); accepts++;
    #1 req_valid = 1'b0;
    @(negedge clk);
    check("R7 done next cycle", done, 1);
    check("R7 rdata zero", rdata, 0);
    check("R7 chip never selected", ce_seen, 0);
    repeat (2) @(negedge clk);

    // R8 R9: stream of chained reads across the selection limit
    max_run = 0; gaps = 0;
    for (int k = 0; k < 20; k++) begin
      issue(1'b0, 18'h00010, 16'h0, 2'b11);
      check("R3 stream read data", rdata, 16'h99CD);
    end
    repeat (4) @(negedge clk);
    check("R9 run within limit", (max_run <= LIMIT), 1);
    check("R9 gap inserted", (gaps >= 2), 1);
    check("R8 accesses chained", (max_run > 24), 1);

    // R10: one done per accepted request
    check("R10 done count", dones, accepts);

    // R1: reset in the middle of an access
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00020; req_wdata = 16'h7777; req_mask = 2'b11;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-access reset ce_n", mem_ce_n, 1);
    check("R1 mid-access reset ready", req_ready, 1);
    check("R1 mid-access reset dq_oe", mem_dq_oe, 0);
    check("R2 aborted write not stored", peek(18'h00020), 16'h0000);
    finish_run();
  end
endmodule